// File: doc/BRIEF.md
# Supply and Watchdog Reset Supervisor

This block drives the active-low, open-drain reset line of a host processor. Reset is held whenever an external comparator reports that the supply sits below its trip level. Reset is then kept for a fixed stretch of 1024 ticks of a 4096 Hz enable, which is 250 ms, after the supply comes back. The trip level is picked by a 3-bit select. The block decodes it into a one-hot choice among five comparator levels.

A watchdog counts the same ticks. It can time out after 1024, 3072 or 7168 ticks (0.25 s, 0.75 s or 1.75 s), or it can be turned off. A kick strobe from the host restarts the count. When the watchdog runs out, reset is asserted and the full 1024-tick stretch is produced again. While the block runs from the backup battery, the watchdog is held and cannot expire. The serial bus interface is gated off while reset is asserted, unless a configuration bit keeps the bus alive.

Top module: `supv_reset_top`

## Requirements
- R1: After the asynchronous reset input is released, and before any configuration write: the reset pin enable is 1, the bus enable is 0, the threshold level output is 5'b00001, the watchdog select is off (2'b11) and the bus-keep bit is 0.
- R2: While the supply flag is 0, the reset pin enable is 1 in the cycle after the flag is sampled, and the stretch count is cleared.
- R3: The reset pin enable falls in the cycle after the 1024th tick that is sampled while the supply flag is 1 and the pin enable is 1.
- R4: The threshold select codes 3'b000 to 3'b100 drive threshold level output bit 0 to bit 4 alone, one cycle after the configuration write.
- R5: The threshold select codes 3'b101, 3'b110 and 3'b111 drive level output 5'b00001, the same as code 3'b000.
- R6: Watchdog select 2'b00, 2'b01 and 2'b10 give timeouts of 1024, 3072 and 7168 ticks after reset is released. Select 2'b11 turns the watchdog off. If a write shortens the timeout below the ticks already counted, the watchdog expires on the next tick.
- R7: When the watchdog expires, the reset pin enable is 1 in the next cycle, the 1024-tick stretch restarts, and the watchdog counts again from zero once reset is released.
- R8: A kick that is sampled while the watchdog runs clears its count, and the kick wins over a tick in the same cycle.
- R9: While the battery-mode input is 1, the watchdog count stays at zero and never expires.
- R10: The bus enable is 1 when the reset pin enable is 0, or when the bus-keep bit is 1. Otherwise it is 0.
- R11: The stretch and watchdog counts advance only in cycles with the tick enable at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's own logic |
| tick_i | input | 1 | 4096 Hz one-cycle enable |
| supply_ok_i | input | 1 | Comparator flag: supply is above the chosen trip level |
| batt_mode_i | input | 1 | Device is running from the backup supply |
| kick_i | input | 1 | Watchdog restart strobe from the host |
| cfg_we_i | input | 1 | Loads the three configuration fields below |
| cfg_thr_i | input | 3 | Trip-level select, codes 0 to 4 valid, 5 to 7 act as 0 |
| cfg_wd_i | input | 2 | Watchdog select: 00 short, 01 medium, 10 long, 11 off |
| cfg_keep_i | input | 1 | 1 keeps the bus enabled while reset is asserted |
| thr_level_o | output | 5 | One-hot trip-level choice for the comparator |
| rst_pin_en_o | output | 1 | 1 turns on the open-drain pull-down of the reset pin |
| bus_enable_o | output | 1 | 1 lets the serial interface operate |

## Verification
The block's state shows up on its ports only through the timing of the reset pin enable. A stretch or watchdog count that is off by one moves a release edge or an expiry edge by a whole tick. A comparison made every cycle therefore shows the fault at the first edge that follows, which can come thousands of cycles after the fault arises. A wrong decode of the select or of the bus-keep bit is visible one cycle after the write, on the level output or on the bus enable. The bench therefore measures the exact cycle counts to release and to expiry for each timeout, and it does so under both dense and sparse tick patterns.

// File: rtl/supv_pkg.sv
package supv_pkg;
   typedef enum logic [1:0] {
      WD_SHORT = 2'b00,
      WD_MID   = 2'b01,
      WD_LONG  = 2'b10,
      WD_OFF   = 2'b11
   } wd_sel_e;

   localparam int unsigned STRETCH_TICKS_DEF = 1024;
   localparam int unsigned WD_SHORT_DEF      = 1024;
   localparam int unsigned WD_MID_DEF        = 3072;
   localparam int unsigned WD_LONG_DEF       = 7168;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/supv_cfg_regs.sv
module supv_cfg_regs
   import supv_pkg::*;
#(
   parameter int unsigned SEL_W    = 3,
   parameter int unsigned THR_RST  = 0,
   parameter wd_sel_e     WD_RST   = WD_OFF,
   parameter bit          KEEP_RST = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [SEL_W-1:0] thr_i,
   input  logic [1:0]       wd_i,
   input  logic             keep_i,
   output logic [SEL_W-1:0] thr_o,
   output wd_sel_e          wd_o,
   output logic             keep_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_o  <= SEL_W'(THR_RST);
         wd_o   <= WD_RST;
         keep_o <= KEEP_RST;
      end else if (we_i) begin
         thr_o  <= thr_i;
         wd_o   <= wd_sel_e'(wd_i);
         keep_o <= keep_i;
      end
   end
endmodule

// File: rtl/supv_thr_decode.sv
module supv_thr_decode #(
   parameter int unsigned SEL_W    = 3,
   parameter int unsigned N_LEVELS = 5
) (
   input  logic [SEL_W-1:0]    sel_i,
   output logic [N_LEVELS-1:0] level_o
);
   if (N_LEVELS > (1 << SEL_W)) begin : g_bad_levels
      $error("supv_thr_decode: N_LEVELS exceeds select range");
   end
   if (N_LEVELS < 2) begin : g_few_levels
      $error("supv_thr_decode: need at least two levels");
   end

   logic reserved;
   assign reserved = (32'(sel_i) >= N_LEVELS);

   for (genvar i = 0; i < N_LEVELS; i++) begin : g_lvl
      if (i == 0) begin : g_base
         assign level_o[i] = reserved || (sel_i == SEL_W'(0));
      end else begin : g_other
         assign level_o[i] = (sel_i == SEL_W'(i));
      end
   end
endmodule

// File: rtl/supv_watchdog.sv
module supv_watchdog
   import supv_pkg::*;
#(
   parameter int unsigned CNT_W   = 13,
   parameter int unsigned T_SHORT = WD_SHORT_DEF,
   parameter int unsigned T_MID   = WD_MID_DEF,
   parameter int unsigned T_LONG  = WD_LONG_DEF
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    tick_i,
   input  logic    kick_i,
   input  logic    hold_i,
   input  wd_sel_e sel_i,
   output logic    expire_o
);
   if (T_SHORT < 2 || T_MID < 2 || T_LONG < 2) begin : g_bad_t
      $error("supv_watchdog: timeouts must be at least two ticks");
   end
   if (T_LONG > (1 << CNT_W)) begin : g_bad_w
      $error("supv_watchdog: CNT_W too narrow for T_LONG");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last;
   logic             run;
   logic             at_end;

   always_comb begin
      unique case (sel_i)
         WD_SHORT: last = CNT_W'(T_SHORT - 1);
         WD_MID:   last = CNT_W'(T_MID - 1);
         WD_LONG:  last = CNT_W'(T_LONG - 1);
         default:  last = '1;
      endcase
   end

   assign run      = (sel_i != WD_OFF) && !hold_i;
   assign at_end   = (cnt_q >= last);
   assign expire_o = run && !kick_i && tick_i && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || kick_i) begin
         cnt_q <= '0;
      end else if (tick_i) begin
         cnt_q <= at_end ? '0 : cnt_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/supv_stretch.sv
module supv_stretch #(
   parameter int unsigned CNT_W = 10,
   parameter int unsigned TICKS = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic supply_ok_i,
   input  logic wd_expire_i,
   output logic active_o
);
   if (TICKS < 2 || TICKS > (1 << CNT_W)) begin : g_bad_ticks
      $error("supv_stretch: TICKS out of range for CNT_W");
   end

   localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_o <= 1'b1;
         cnt_q    <= '0;
      end else if (!supply_ok_i || wd_expire_i) begin
         active_o <= 1'b1;
         cnt_q    <= '0;
      end else if (active_o && tick_i) begin
         if (cnt_q == LAST) begin
            active_o <= 1'b0;
            cnt_q    <= '0;
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/supv_reset_top.sv
module supv_reset_top
   import supv_pkg::*;
#(
   parameter int unsigned SEL_W         = 3,
   parameter int unsigned N_LEVELS      = 5,
   parameter int unsigned STRETCH_TICKS = STRETCH_TICKS_DEF,
   parameter int unsigned T_SHORT       = WD_SHORT_DEF,
   parameter int unsigned T_MID         = WD_MID_DEF,
   parameter int unsigned T_LONG        = WD_LONG_DEF,
   parameter bit          GATE_BUS      = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick_i,
   input  logic                supply_ok_i,
   input  logic                batt_mode_i,
   input  logic                kick_i,
   input  logic                cfg_we_i,
   input  logic [SEL_W-1:0]    cfg_thr_i,
   input  logic [1:0]          cfg_wd_i,
   input  logic                cfg_keep_i,
   output logic [N_LEVELS-1:0] thr_level_o,
   output logic                rst_pin_en_o,
   output logic                bus_enable_o
);
   localparam int unsigned WD_MAX = max2(T_SHORT, max2(T_MID, T_LONG));
   localparam int unsigned WD_W   = $clog2(WD_MAX + 1);
   localparam int unsigned ST_W   = $clog2(STRETCH_TICKS + 1);

   logic [SEL_W-1:0] thr_q;
   wd_sel_e          wd_q;
   logic             keep_q;
   logic             wd_expire;
   logic             active;

   supv_cfg_regs #(.SEL_W(SEL_W)) i_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (cfg_we_i),
      .thr_i (cfg_thr_i),
      .wd_i  (cfg_wd_i),
      .keep_i(cfg_keep_i),
      .thr_o (thr_q),
      .wd_o  (wd_q),
      .keep_o(keep_q)
   );

   supv_thr_decode #(.SEL_W(SEL_W), .N_LEVELS(N_LEVELS)) i_dec (
      .sel_i  (thr_q),
      .level_o(thr_level_o)
   );

   supv_watchdog #(
      .CNT_W(WD_W), .T_SHORT(T_SHORT), .T_MID(T_MID), .T_LONG(T_LONG)
   ) i_wd (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick_i),
      .kick_i  (kick_i),
      .hold_i  (batt_mode_i || active),
      .sel_i   (wd_q),
      .expire_o(wd_expire)
   );

   supv_stretch #(.CNT_W(ST_W), .TICKS(STRETCH_TICKS)) i_st (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick_i),
      .supply_ok_i(supply_ok_i),
      .wd_expire_i(wd_expire),
      .active_o   (active)
   );

   assign rst_pin_en_o = active;

   if (GATE_BUS) begin : g_gate
      assign bus_enable_o = !active || keep_q;
   end else begin : g_nogate
      assign bus_enable_o = 1'b1;
   end
endmodule

// File: rtl/supv_reset_chk.sv
module supv_reset_chk #(
   parameter int unsigned N_LEVELS = 5
) (
   input logic                clk,
   input logic                rst_n,
   input logic                tick_i,
   input logic                supply_ok_i,
   input logic                batt_mode_i,
   input logic                cfg_we_i,
   input logic [2:0]          cfg_thr_i,
   input logic [N_LEVELS-1:0] thr_level_o,
   input logic                rst_pin_en_o,
   input logic                bus_enable_o,
   input logic                wd_expire
);
   a_r2_low_supply_resets: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok_i |=> rst_pin_en_o);

   a_r4_level_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(thr_level_o) == 1);

   a_r5_reserved_base: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we_i && cfg_thr_i >= 3'd5) |=> thr_level_o == N_LEVELS'(1));

   a_r7_expire_resets: assert property (@(posedge clk) disable iff (!rst_n)
      wd_expire |=> rst_pin_en_o);

   a_r9_batt_no_expire: assert property (@(posedge clk) disable iff (!rst_n)
      batt_mode_i |-> !wd_expire);

   a_r10_bus_open_when_released: assert property (@(posedge clk) disable iff (!rst_n)
      !rst_pin_en_o |-> bus_enable_o);

   a_r11_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_pin_en_o) |-> $past(tick_i));
endmodule

bind supv_reset_top supv_reset_chk #(.N_LEVELS(N_LEVELS)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick_i      (tick_i),
   .supply_ok_i (supply_ok_i),
   .batt_mode_i (batt_mode_i),
   .cfg_we_i    (cfg_we_i),
   .cfg_thr_i   (cfg_thr_i),
   .thr_level_o (thr_level_o),
   .rst_pin_en_o(rst_pin_en_o),
   .bus_enable_o(bus_enable_o),
   .wd_expire   (wd_expire)
);

// File: tb/test_supv_reset_top.sv
`timescale 1ns/1ps
module test_supv_reset_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0;
   logic       supply_ok_i = 1'b0;
   logic       batt_mode_i = 1'b0;
   logic       kick_i = 1'b0;
   logic       cfg_we_i = 1'b0;
   logic [2:0] cfg_thr_i = 3'd0;
   logic [1:0] cfg_wd_i = 2'b11;
   logic       cfg_keep_i = 1'b0;
   logic [4:0] thr_level_o;
   logic       rst_pin_en_o;
   logic       bus_enable_o;

   int checks = 0;
   int errors = 0;
   int tick_div = 1;
   int tick_ph = 0;
   int cycles = 0;
   string cur_req = "R1";

   // reference model state
   bit m_active = 1'b1;
   int m_pcnt = 0;
   int m_wcnt = 0;
   int m_thr = 0;
   int m_wd = 3;
   bit m_keep = 1'b0;

   // bench copies of the configuration fields
   int b_thr = 0;
   int b_wd = 3;
   bit b_keep = 1'b0;

   always #2.5 clk = ~clk;

   supv_reset_top i_supv_reset_top (.*);

   function automatic int wd_limit(input int sel);
      case (sel)
         0: return 1024;
         1: return 3072;
         2: return 7168;
         default: return 0;
      endcase
   endfunction

   function automatic int exp_level(input int s);
      return (s < 5) ? (1 << s) : 1;
   endfunction

   task automatic check(input string req, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d at cycle %0d", req, what, act, exp, cycles);
      end
   endtask

   // tick generator
   always @(negedge clk) begin
      tick_ph = (tick_ph + 1) % tick_div;
      tick_i <= (tick_ph == 0);
      cycles++;
   end

   // behavioural reference, one step per clock
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_active = 1'b1; m_pcnt = 0; m_wcnt = 0;
         m_thr = 0; m_wd = 3; m_keep = 1'b0;
      end else begin
         bit fire;
         bit runs;
         fire = 1'b0;
         runs = (m_wd != 3) && !batt_mode_i && !m_active;
         if (!runs || kick_i) m_wcnt = 0;
         else if (tick_i) begin
            if (m_wcnt >= wd_limit(m_wd) - 1) begin fire = 1'b1; m_wcnt = 0; end
            else m_wcnt = m_wcnt + 1;
         end
         if (!supply_ok_i || fire) begin
            m_active = 1'b1; m_pcnt = 0;
         end else if (m_active && tick_i) begin
            if (m_pcnt == 1023) begin m_active = 1'b0; m_pcnt = 0; end
            else m_pcnt = m_pcnt + 1;
         end
         if (cfg_we_i) begin
            m_thr = int'(cfg_thr_i); m_wd = int'(cfg_wd_i); m_keep = cfg_keep_i;
         end
      end
   end

   // every-cycle comparison
   always @(negedge clk) begin
      if (rst_n) begin
         check(cur_req, int'(rst_pin_en_o), int'(m_active), "pin enable vs model");
         check("R10", int'(bus_enable_o), int'(!m_active || m_keep), "bus enable vs model");
         check(cur_req == "R5" ? "R5" : "R4", int'(thr_level_o), exp_level(m_thr), "level vs model");
      end
   end

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic cfg(input int thr, input int wd, input bit keep);
      @(negedge clk);
      b_thr = thr; b_wd = wd; b_keep = keep;
      cfg_thr_i = 3'(thr); cfg_wd_i = 2'(wd); cfg_keep_i = keep; cfg_we_i = 1'b1;
      @(negedge clk);
      cfg_we_i = 1'b0;
   endtask

   task automatic wait_release(input string req);
      int n;
      n = 0;
      while (rst_pin_en_o && n < 40000) begin @(negedge clk); n++; end
      check(req, int'(rst_pin_en_o), 0, "reset released");
   endtask

   task automatic measure_wd(input int sel, input string req);
      int n;
      cfg(b_thr, sel, b_keep);
      wait_release(req);
      n = 0;
      while (!rst_pin_en_o && n < 10000) begin @(negedge clk); n++; end
      check(req, n, wd_limit(sel), "cycles from release to expiry");
   endtask

   initial begin
      cyc(3);
      rst_n = 1'b1;
      @(negedge clk);
      cur_req = "R1";
      check("R1", int'(rst_pin_en_o), 1, "pin enable after reset");
      check("R1", int'(bus_enable_o), 0, "bus enable after reset");
      check("R1", int'(thr_level_o), 1, "level after reset");

      // R3: power-on stretch with a tick every cycle
      cur_req = "R3";
      supply_ok_i = 1'b1;
      cyc(1020);
      check("R3", int'(rst_pin_en_o), 1, "still held before 1024 ticks");
      wait_release("R3");

      // R4 / R5: threshold decode
      for (int s = 0; s < 8; s++) begin
         cur_req = (s < 5) ? "R4" : "R5";
         cfg(s, 3, 1'b0);
         @(negedge clk);
         check(cur_req, int'(thr_level_o), exp_level(s), "level for select code");
      end
      cfg(2, 3, 1'b0);

      // R2 / R10: supply drop with and without bus keep
      cur_req = "R2";
      cfg(2, 3, 1'b1);
      supply_ok_i = 1'b0;
      cyc(2);
      check("R2", int'(rst_pin_en_o), 1, "pin enable on low supply");
      check("R10", int'(bus_enable_o), 1, "bus kept alive by keep bit");
      cfg(2, 3, 1'b0);
      check("R10", int'(bus_enable_o), 0, "bus gated without keep bit");
      supply_ok_i = 1'b1;
      cyc(500);
      supply_ok_i = 1'b0;
      @(negedge clk);
      supply_ok_i = 1'b1;
      cyc(1020);
      check("R2", int'(rst_pin_en_o), 1, "dip restarted the stretch");
      wait_release("R2");

      // R11: sparse ticks
      cur_req = "R11";
      tick_div = 4;
      supply_ok_i = 1'b0;
      cyc(3);
      supply_ok_i = 1'b1;
      cyc(4000);
      check("R11", int'(rst_pin_en_o), 1, "held until 1024 sparse ticks");
      wait_release("R11");
      tick_div = 1;
      cyc(4);

      // R6: watchdog timeouts
      cur_req = "R6";
      measure_wd(0, "R6");
      cur_req = "R7";
      measure_wd(0, "R7");
      cur_req = "R6";
      measure_wd(1, "R6");
      measure_wd(2, "R6");
      cfg(b_thr, 3, 1'b0);
      wait_release("R6");
      cyc(8000);
      check("R6", int'(rst_pin_en_o), 0, "off select never expires");

      // shortened timeout expires on next tick
      cfg(b_thr, 2, 1'b0);
      cyc(2000);
      cfg(b_thr, 0, 1'b0);
      cyc(2);
      check("R6", int'(rst_pin_en_o), 1, "shortened timeout expires at once");

      // R8: kicks keep the host alive, kick beats tick
      cur_req = "R8";
      wait_release("R8");
      for (int k = 0; k < 6; k++) begin
         cyc(1000);
         kick_i = 1'b1;
         @(negedge clk);
         kick_i = 1'b0;
      end
      check("R8", int'(rst_pin_en_o), 0, "kicked watchdog stays quiet");

      // R9: battery mode holds the watchdog
      cur_req = "R9";
      batt_mode_i = 1'b1;
      cyc(3000);
      check("R9", int'(rst_pin_en_o), 0, "no expiry in battery mode");
      batt_mode_i = 1'b0;
      cyc(1030);
      check("R9", int'(rst_pin_en_o), 1, "watchdog runs after battery mode");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #1000000;
      errors++;
      $display("FAIL watchdog expired at cycle %0d during %s", cycles, cur_req);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule